// File: doc/BRIEF.md
# Recursive Conditional-Sum Adder

A combinational adder of parameterised width (16 bits by default) that avoids a rippling carry. Every bit position forms two candidate results in advance: one that assumes no carry arrives and one that assumes a carry does. Each candidate has its own sum bit and carry out.

Neighbouring segments are then joined pairwise, level by level. At each join, the two conditional carries of the lower segment pick, through 2:1 multiplexers, which of the upper segment's conditional results belongs to each case. After log2(WIDTH) levels a single segment covers the whole word. The real carry-in then chooses between its two complete candidates.

The block has no clock and no state. It sits between registers that belong to the surrounding datapath.

Top module: `cs_adder`

## Requirements
- R1: `sum` equals the low WIDTH bits of `op_a + op_b + carry_in`, for every operand pair.
- R2: `carry_out` equals bit WIDTH (the bit just above the word) of `op_a + op_b + carry_in`.
- R3: Each bit cell forms its results ahead of time. Assuming no incoming carry, the sum bit is a XOR b and the carry is a AND b. Assuming an incoming carry, the sum bit is a XNOR b and the carry is a OR b. At bit 0 this is observable through `carry_in`.
- R4: In every segment at every level, the carry-assumed result {carry, sum} equals the no-carry result plus one. A set no-carry carry implies a set carry-assumed carry.
- R5: For fixed operands, raising `carry_in` from 0 to 1 increases {`carry_out`, `sum`} by exactly one, modulo 2^(WIDTH+1).
- R6: A carry entering at bit 0 reaches the top of the word. All-ones plus zero plus carry-in 1 gives `sum` = 0 and `carry_out` = 1. All-ones plus all-ones plus 1 gives `sum` = all-ones and `carry_out` = 1.
- R7: WIDTH must be a power of two and at least 2, and the join tree has log2(WIDTH) levels. An 8-bit instance is correct for all 2^17 input combinations.
- R8: The block is purely combinational. Results depend only on the current inputs, and there is no clock or reset port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0; picks the final candidate |
| sum | output | WIDTH | Low WIDTH bits of the total |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
A wrong multiplexer select or a swapped candidate at some join level shows as a wrong `sum` or `carry_out`. It appears in the same evaluation as the operands that exercise that join. Only carry patterns that cross that segment boundary reveal it, so the exhaustive 8-bit sweep reaches every join of the narrow tree. Random and directed carry-chain patterns cover the joins of the 16-bit tree. Candidate pairs that break the plus-one relation are flagged inside the join where they arise, before any later selection can hide them.

// File: rtl/cs_adder_pkg.sv
package cs_adder_pkg;

    // Start of level 'lvl' within the flat per-segment carry vector.
    // Level m holds (width >> m) segments, so the offset is the sum of the
    // segment counts of all earlier levels.
    function automatic int cy_base(input int width, input int lvl);
        return 2 * width - 2 * (width >> lvl);
    endfunction

    function automatic bit is_pow2(input int v);
        return (v >= 2) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/cs_leaf.sv
module cs_leaf (
    input  logic a,
    input  logic b,
    output logic s_nc,
    output logic s_wc,
    output logic cy_nc,
    output logic cy_wc
);
    // R3: results with no incoming carry and with an incoming carry
    always_comb begin
        s_nc  = a ^ b;
        cy_nc = a & b;
        s_wc  = ~(a ^ b);
        cy_wc = a | b;
    end

    always_comb begin
        if (!$isunknown({a, b})) begin
            // R4
            leaf_step_chk: assert ({cy_wc, s_wc} == {cy_nc, s_nc} + 2'd1)
                else $error("leaf candidates not one apart");
        end
    end
endmodule

// File: rtl/cs_merge.sv
module cs_merge #(
    parameter int HALF = 1
) (
    input  logic [HALF-1:0]   lo_s_nc,
    input  logic [HALF-1:0]   lo_s_wc,
    input  logic              lo_cy_nc,
    input  logic              lo_cy_wc,
    input  logic [HALF-1:0]   hi_s_nc,
    input  logic [HALF-1:0]   hi_s_wc,
    input  logic              hi_cy_nc,
    input  logic              hi_cy_wc,
    output logic [2*HALF-1:0] m_s_nc,
    output logic [2*HALF-1:0] m_s_wc,
    output logic              m_cy_nc,
    output logic              m_cy_wc
);
    localparam int OW = 2 * HALF + 1;

    // The lower half passes straight through. The upper half (sum bits
    // plus carry) is chosen by the lower half's carry for each case.
    always_comb begin
        m_s_nc  = {(lo_cy_nc ? hi_s_wc : hi_s_nc), lo_s_nc};
        m_cy_nc =  lo_cy_nc ? hi_cy_wc : hi_cy_nc;
        m_s_wc  = {(lo_cy_wc ? hi_s_wc : hi_s_nc), lo_s_wc};
        m_cy_wc =  lo_cy_wc ? hi_cy_wc : hi_cy_nc;
    end

    always_comb begin
        if (!$isunknown({lo_cy_nc, lo_cy_wc, hi_cy_nc, hi_cy_wc})) begin
            // R4
            lower_carry_order_chk: assert (!(lo_cy_nc && !lo_cy_wc))
                else $error("lower segment carry order violated");
            // R4
            upper_carry_order_chk: assert (!(hi_cy_nc && !hi_cy_wc))
                else $error("upper segment carry order violated");
        end
        if (!$isunknown({m_s_nc, m_s_wc, m_cy_nc, m_cy_wc})) begin
            // R4
            merge_step_chk: assert ({m_cy_wc, m_s_wc} == {m_cy_nc, m_s_nc} + OW'(1))
                else $error("merged candidates not one apart");
        end
    end
endmodule

// File: rtl/cs_pick.sv
module cs_pick #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] s_nc,
    input  logic [WIDTH-1:0] s_wc,
    input  logic             cy_nc,
    input  logic             cy_wc,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    // R8: final selection by the real carry-in, no storage
    always_comb begin
        sum  = cin ? s_wc  : s_nc;
        cout = cin ? cy_wc : cy_nc;
    end
endmodule

// File: rtl/cs_adder.sv
module cs_adder
    import cs_adder_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);
    localparam int LEVELS = $clog2(WIDTH);
    localparam int CYBITS = 2 * WIDTH - 1;

    // R7: width must allow a balanced pairwise tree
    if (!is_pow2(WIDTH)) begin : g_bad_width
        $error("cs_adder: WIDTH must be a power of two and at least 2");
    end

    logic [WIDTH-1:0]  lv_s_nc [0:LEVELS];
    logic [WIDTH-1:0]  lv_s_wc [0:LEVELS];
    logic [CYBITS-1:0] cy_nc_all;
    logic [CYBITS-1:0] cy_wc_all;

    for (genvar lv = 0; lv <= LEVELS; lv++) begin : g_lvl
        localparam int NSEG = WIDTH >> lv;
        localparam int SEG  = 1 << lv;
        localparam int BASE = cy_base(WIDTH, lv);
        if (lv == 0) begin : g_leaves
            for (genvar k = 0; k < WIDTH; k++) begin : g_bit
                cs_leaf u_leaf (
                    .a     (op_a[k]),
                    .b     (op_b[k]),
                    .s_nc  (lv_s_nc[0][k]),
                    .s_wc  (lv_s_wc[0][k]),
                    .cy_nc (cy_nc_all[BASE + k]),
                    .cy_wc (cy_wc_all[BASE + k])
                );
            end
        end else begin : g_joins
            localparam int HALF  = SEG / 2;
            localparam int PBASE = cy_base(WIDTH, lv - 1);
            for (genvar j = 0; j < NSEG; j++) begin : g_seg
                cs_merge #(.HALF(HALF)) u_merge (
                    .lo_s_nc  (lv_s_nc[lv-1][2*j*HALF +: HALF]),
                    .lo_s_wc  (lv_s_wc[lv-1][2*j*HALF +: HALF]),
                    .lo_cy_nc (cy_nc_all[PBASE + 2*j]),
                    .lo_cy_wc (cy_wc_all[PBASE + 2*j]),
                    .hi_s_nc  (lv_s_nc[lv-1][(2*j+1)*HALF +: HALF]),
                    .hi_s_wc  (lv_s_wc[lv-1][(2*j+1)*HALF +: HALF]),
                    .hi_cy_nc (cy_nc_all[PBASE + 2*j + 1]),
                    .hi_cy_wc (cy_wc_all[PBASE + 2*j + 1]),
                    .m_s_nc   (lv_s_nc[lv][j*SEG +: SEG]),
                    .m_s_wc   (lv_s_wc[lv][j*SEG +: SEG]),
                    .m_cy_nc  (cy_nc_all[BASE + j]),
                    .m_cy_wc  (cy_wc_all[BASE + j])
                );
            end
        end
    end

    cs_pick #(.WIDTH(WIDTH)) u_pick (
        .s_nc  (lv_s_nc[LEVELS]),
        .s_wc  (lv_s_wc[LEVELS]),
        .cy_nc (cy_nc_all[CYBITS-1]),
        .cy_wc (cy_wc_all[CYBITS-1]),
        .cin   (carry_in),
        .sum   (sum),
        .cout  (carry_out)
    );

    always_comb begin
        if (!$isunknown({op_a, op_b, carry_in, sum, carry_out})) begin
            // R1 R2
            total_value_chk: assert ({carry_out, sum} ==
                                     ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}))
                else $error("adder total mismatch");
        end
    end
endmodule

// File: tb/cs_adder_test.sv
module cs_adder_test;
    localparam int WW = 16;
    localparam int WN = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [WW-1:0] a_w, b_w, s_w;
    logic          ci_w, co_w;
    logic [WN-1:0] a_n, b_n, s_n;
    logic          ci_n, co_n;

    cs_adder #(.WIDTH(WW)) uut (
        .op_a(a_w), .op_b(b_w), .carry_in(ci_w), .sum(s_w), .carry_out(co_w));
    cs_adder #(.WIDTH(WN)) uut_narrow (
        .op_a(a_n), .op_b(b_n), .carry_in(ci_n), .sum(s_n), .carry_out(co_n));

    typedef struct {
        string       req;
        logic [WW:0] exp_w;
        logic [WN:0] exp_n;
        bit          use_n;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic drive(input logic [WW-1:0] a, input logic [WW-1:0] b, input logic c,
                         input logic [WN-1:0] an, input logic [WN-1:0] bn, input logic cn,
                         input bit use_n, input string req);
        item_t it;
        @(posedge clk);
        #1;
        a_w = a; b_w = b; ci_w = c;
        a_n = an; b_n = bn; ci_n = cn;
        it.req   = req;
        it.exp_w = {1'b0, a} + {1'b0, b} + {{WW{1'b0}}, c};
        it.exp_n = {1'b0, an} + {1'b0, bn} + {{WN{1'b0}}, cn};
        it.use_n = use_n;
        q.push_back(it);
    endtask

    task automatic wide(input logic [WW-1:0] a, input logic [WW-1:0] b, input logic c,
                        input string req);
        drive(a, b, c, '0, '0, 1'b0, 1'b0, req);
    endtask

    // monitor: compares mid-cycle, after inputs driven just past the rising edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if ({co_w, s_w} !== it.exp_w) begin
                errors++;
                $display("FAIL %s wide: got %h expected %h", it.req, {co_w, s_w}, it.exp_w);
            end
            if (it.use_n) begin
                checks++;
                if ({co_n, s_n} !== it.exp_n) begin
                    errors++;
                    $display("FAIL %s narrow: got %h expected %h", it.req, {co_n, s_n}, it.exp_n);
                end
            end
        end
    end

    initial begin
        a_w = '0; b_w = '0; ci_w = 1'b0;
        a_n = '0; b_n = '0; ci_n = 1'b0;
        repeat (3) @(posedge clk);
        // R8: zero inputs give zero outputs, no clock or reset in the block
        drive('0, '0, 1'b0, '0, '0, 1'b0, 1'b1, "R8 idle");
        rst_n = 1'b1;

        // R3: bit-0 cell under all four a/b values and both carries
        for (int v = 0; v < 8; v++)
            drive(WW'(v[0]), WW'(v[1]), v[2], WN'(v[0]), WN'(v[1]), v[2], 1'b1, "R3 leaf");
        // R3: every bit position, generate and propagate
        for (int k = 0; k < WW; k++) begin
            wide(WW'(1) << k, '0, 1'b0, "R3 propagate");
            wide(WW'(1) << k, WW'(1) << k, 1'b0, "R3 generate");
        end
        // R6: carry travels the whole word
        drive('1, '0, 1'b1, '1, '0, 1'b1, 1'b1, "R6 chain");
        drive('1, '1, 1'b1, '1, '1, 1'b1, 1'b1, "R6 chain full");
        wide(16'h00FF, 16'h0001, 1'b0, "R6 half chain");
        wide(16'h7FFF, 16'h0000, 1'b1, "R6 top chain");
        // R2: carry out cases
        wide(16'hFFFF, 16'h0001, 1'b0, "R2 wrap");
        wide(16'h8000, 16'h8000, 1'b0, "R2 top generate");
        wide(16'h8000, 16'h7FFF, 1'b0, "R2 no carry");
        // R5: same operands, carry-in toggled
        for (int i = 0; i < 20; i++) begin
            logic [WW-1:0] ra, rb;
            ra = WW'($urandom);
            rb = WW'($urandom);
            wide(ra, rb, 1'b0, "R5 cin0");
            wide(ra, rb, 1'b1, "R5 cin1");
        end
        // R4: segment boundary patterns at every level
        for (int lv = 0; lv < 4; lv++) begin
            int seg;
            seg = 1 << lv;
            wide((WW'(1) << seg) - 1, WW'(1), 1'b0, "R4 boundary");
            wide((WW'(1) << seg) - 1, '0, 1'b1, "R4 boundary cin");
        end
        // R7 exhaustive narrow, R1 random wide in the same cycles
        for (int x = 0; x < 256; x++)
            for (int y = 0; y < 256; y++)
                for (int c = 0; c < 2; c++)
                    drive(WW'($urandom), WW'($urandom), 1'($urandom),
                          WN'(x), WN'(y), c[0], 1'b1, "R7 R1 sweep");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule